// File: doc/BRIEF.md
# Auxiliary ADC Register Front End

This block gives software a small word-addressed register window onto an eight-channel, ten-bit auxiliary converter core. Software selects a channel and a conversion mode, asks for a conversion, and then polls a done flag. It reads the ten-bit code together with the number of the channel that produced it. The block drives the core's power-down, channel-select, single-mode and start pins, and it latches the code and channel that the core hands back.

The converter needs time to settle after it is powered up. The block counts converter clock cycles from each power-up and does not let a start reach the core until that window has run out. A start that software writes too early is kept pending and is launched as soon as the converter is allowed to start. A power-down cancels it. A synchronous behavioural stub inside the top stands in for the analog core. It returns a fixed code for each channel after a fixed number of cycles.

Top module: `aux_adc_ctrl`

## Requirements
- R1: After reset the converter is powered down. The power register (0x10) reads 1 and every other mapped register reads 0.
- R2: A write to 0x00 stores the channel from bits 2:0 and single mode from bit 5. Reading 0x00 returns them in the same positions, with bits 3 and 31:6 zero.
- R3: Writing 1 to bit 4 of 0x00 makes a start request pending, and bit 4 reads 1. The bit clears by itself in the cycle that the start reaches the core. Writing 0 to bit 4 leaves a pending request untouched.
- R4: coreStart is never high until 8 clock edges have passed since the edge that powered the converter up. A pending start is launched in the cycle right after the 8th edge.
- R5: A start written while the converter is powered down stays pending. It launches once the converter is powered up and the settle window has passed.
- R6: Writing 1 to bit 0 of 0x10 powers the converter down and drives corePowerDown high. It also discards a pending start and aborts a running conversion. Reading 0x10 returns the power-down state in bit 0.
- R7: Writing 0 to 0x10 while the converter is already powered up does not restart the settle window.
- R8: coreStart is a one-cycle pulse. During that cycle coreChanSel equals the stored channel and coreSingleMode equals the stored mode bit. The done flag clears on the launch edge.
- R9: Four cycles after launch, the result register (0x04) holds the code 100 + 100 x channel and the sampled-channel register (0x0C) holds the channel. Bit 0 of 0x08 reads 1.
- R10: Reads of unmapped or misaligned addresses return 0. The result register reads 0 in bits 31:10.
- R11: A start written while a conversion is running stays pending and launches after that conversion completes.
- R12: If the converter is powered down during a conversion, the done flag stays clear and the previously latched result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| corePowerDown | output | 1 | Converter power-down |
| coreChanSel | output | 3 | Channel presented to the converter |
| coreSingleMode | output | 1 | Single-conversion mode to the converter |
| coreStart | output | 1 | One-cycle conversion start pulse |

## Verification
A settle counter left in the wrong state shows up in the first cycle of a conversion request, because coreStart moves earlier or later than the 8th edge after power-up. A lost or stuck pending flag shows at once in bit 4 of the configuration read-back, and later as a missing or extra start pulse. A wrong channel or result capture shows four cycles after launch, in the result, sampled-channel and done registers. A reference model compares every core pin and the read-back at the current address on every clock, so any of these faults is reported in the cycle it first appears.

// File: rtl/aux_adc_pkg.sv
package aux_adc_pkg;
  // register byte offsets
  localparam int OFF_CFG     = 0;
  localparam int OFF_RESULT  = 4;
  localparam int OFF_EOC     = 8;
  localparam int OFF_SAMPLED = 12;
  localparam int OFF_POWER   = 16;

  // configuration field positions
  localparam int CFG_START_BIT  = 4;
  localparam int CFG_SINGLE_BIT = 5;

  // control-to-datapath strobes
  typedef struct packed {
    logic launch;
    logic pending;
    logic powerDown;
  } ctlStrobe_t;
endpackage

// File: rtl/aux_adc_ctl.sv
module aux_adc_ctl
  import aux_adc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrCfg,
  input  logic       wrPwr,
  input  logic       startBit,
  input  logic       pwrBit,
  input  logic       convBusy,
  output ctlStrobe_t strobes
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] settleCnt;
  logic pwrDown;
  logic pending;
  logic settled;
  logic launch;

  assign settled = (settleCnt == CNT_W'(SETTLE_CYCLES));
  assign launch  = pending && !pwrDown && settled && !convBusy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwrDown   <= 1'b1;
      pending   <= 1'b0;
      settleCnt <= '0;
    end else if (wrPwr && pwrBit) begin
      pwrDown   <= 1'b1;
      pending   <= 1'b0;
      settleCnt <= '0;
    end else begin
      if (wrPwr && pwrDown) begin
        pwrDown   <= 1'b0;
        settleCnt <= '0;
      end else if (!pwrDown && !settled) begin
        settleCnt <= settleCnt + 1'b1;
      end
      if (wrCfg && startBit) pending <= 1'b1;
      else if (launch)       pending <= 1'b0;
    end
  end

  assign strobes.launch    = launch;
  assign strobes.pending   = pending;
  assign strobes.powerDown = pwrDown;
endmodule

// File: rtl/aux_adc_stub.sv
module aux_adc_stub #(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 10,
  parameter int CONV_CYCLES = 4,
  parameter int CODE_BASE   = 100,
  parameter int CODE_STEP   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              powerDown,
  input  logic              start,
  input  logic [CHAN_W-1:0] chanSel,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] doneData,
  output logic [CHAN_W-1:0] doneChan
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0]  convCnt;
  logic [CHAN_W-1:0] chanHeld;

  assign done     = busy && !powerDown && (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign doneData = DATA_W'(CODE_BASE + CODE_STEP * int'(chanHeld));
  assign doneChan = chanHeld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      convCnt  <= '0;
      chanHeld <= '0;
    end else if (powerDown) begin
      busy <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      convCnt  <= '0;
      chanHeld <= chanSel;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      convCnt <= convCnt + 1'b1;
    end
  end
endmodule

// File: rtl/aux_adc_dp.sv
module aux_adc_dp
  import aux_adc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CHAN_W = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrCfg,
  input  logic [31:0]       busWdata,
  input  ctlStrobe_t        strobes,
  input  logic              convDone,
  input  logic [DATA_W-1:0] doneData,
  input  logic [CHAN_W-1:0] doneChan,
  output logic [31:0]       busRdata,
  output logic [CHAN_W-1:0] cfgChan,
  output logic              cfgSingle
);
  logic [DATA_W-1:0] resultReg;
  logic [CHAN_W-1:0] sampledChan;
  logic              eocFlag;
  logic              unusedWdata;

  assign unusedWdata = ^{busWdata[31:CFG_SINGLE_BIT+1], busWdata[CFG_START_BIT:CHAN_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgChan   <= '0;
      cfgSingle <= 1'b0;
    end else if (wrCfg) begin
      cfgChan   <= busWdata[CHAN_W-1:0];
      cfgSingle <= busWdata[CFG_SINGLE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultReg   <= '0;
      sampledChan <= '0;
      eocFlag     <= 1'b0;
    end else if (strobes.launch) begin
      eocFlag <= 1'b0;
    end else if (convDone) begin
      eocFlag     <= 1'b1;
      resultReg   <= doneData;
      sampledChan <= doneChan;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_CFG)) begin
      busRdata[CHAN_W-1:0]    = cfgChan;
      busRdata[CFG_START_BIT]  = strobes.pending;
      busRdata[CFG_SINGLE_BIT] = cfgSingle;
    end else if (busAddr == ADDR_W'(OFF_RESULT)) begin
      busRdata[DATA_W-1:0] = resultReg;
    end else if (busAddr == ADDR_W'(OFF_EOC)) begin
      busRdata[0] = eocFlag;
    end else if (busAddr == ADDR_W'(OFF_SAMPLED)) begin
      busRdata[CHAN_W-1:0] = sampledChan;
    end else if (busAddr == ADDR_W'(OFF_POWER)) begin
      busRdata[0] = strobes.powerDown;
    end
  end
endmodule

// File: rtl/aux_adc_ctrl.sv
module aux_adc_ctrl
  import aux_adc_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int CHAN_W        = 3,
  parameter int DATA_W        = 10,
  parameter int SETTLE_CYCLES = 8,
  parameter int CONV_CYCLES   = 4,
  parameter int CODE_BASE     = 100,
  parameter int CODE_STEP     = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              corePowerDown,
  output logic [CHAN_W-1:0] coreChanSel,
  output logic              coreSingleMode,
  output logic              coreStart
);
  ctlStrobe_t        strobes;
  logic              wrCfg;
  logic              wrPwr;
  logic              convBusy;
  logic              convDone;
  logic [DATA_W-1:0] doneData;
  logic [CHAN_W-1:0] doneChan;

  assign wrCfg = busWe && (busAddr == ADDR_W'(OFF_CFG));
  assign wrPwr = busWe && (busAddr == ADDR_W'(OFF_POWER));

  aux_adc_ctl #(.SETTLE_CYCLES(SETTLE_CYCLES)) ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrCfg    (wrCfg),
    .wrPwr    (wrPwr),
    .startBit (busWdata[CFG_START_BIT]),
    .pwrBit   (busWdata[0]),
    .convBusy (convBusy),
    .strobes  (strobes)
  );

  aux_adc_dp #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)) dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .wrCfg     (wrCfg),
    .busWdata  (busWdata),
    .strobes   (strobes),
    .convDone  (convDone),
    .doneData  (doneData),
    .doneChan  (doneChan),
    .busRdata  (busRdata),
    .cfgChan   (coreChanSel),
    .cfgSingle (coreSingleMode)
  );

  aux_adc_stub #(
    .CHAN_W(CHAN_W), .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES),
    .CODE_BASE(CODE_BASE), .CODE_STEP(CODE_STEP)
  ) conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .powerDown (strobes.powerDown),
    .start     (strobes.launch),
    .chanSel   (coreChanSel),
    .busy      (convBusy),
    .done      (convDone),
    .doneData  (doneData),
    .doneChan  (doneChan)
  );

  assign corePowerDown = strobes.powerDown;
  assign coreStart     = strobes.launch;
endmodule

// File: rtl/aux_adc_ctrl_chk.sv
module aux_adc_ctrl_chk #(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 10,
  parameter int SETTLE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              corePowerDown,
  input logic              coreStart
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 2);
  logic [CNT_W-1:0] sinceUp;

  always_ff @(posedge clk) begin
    if (!rst_n || corePowerDown) sinceUp <= '0;
    else if (sinceUp < CNT_W'(SETTLE_CYCLES)) sinceUp <= sinceUp + 1'b1;
  end

  // R4
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |-> (sinceUp >= CNT_W'(SETTLE_CYCLES)));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |=> !coreStart);

  // R6
  power_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(16)) |-> (busRdata == {31'b0, corePowerDown}));

  // R10
  result_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(4)) |-> (busRdata[31:DATA_W] == '0));

  // R2
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(0)) |-> (busRdata[31:6] == '0 && busRdata[3] == 1'b0));
endmodule

bind aux_adc_ctrl aux_adc_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE_CYCLES)
) chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busAddr       (busAddr),
  .busRdata      (busRdata),
  .corePowerDown (corePowerDown),
  .coreStart     (coreStart)
);

// File: tb/aux_adc_ctrl_test.sv
`timescale 1ns/1ps
module aux_adc_ctrl_test;
  localparam int SETTLE = 8;
  localparam int CONV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        corePowerDown;
  logic [2:0]  coreChanSel;
  logic        coreSingleMode;
  logic        coreStart;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  aux_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .corePowerDown(corePowerDown),
    .coreChanSel(coreChanSel), .coreSingleMode(coreSingleMode), .coreStart(coreStart)
  );

  // behavioural reference model
  int mPd = 1, mChan = 0, mSingle = 0, mPend = 0, mSettle = 0;
  int mBusy = 0, mBcnt = 0, mCv = 0, mRes = 0, mEoc = 0, mSamp = 0;

  function automatic int modelLaunch();
    return (mPend != 0 && mPd == 0 && mSettle == SETTLE && mBusy == 0) ? 1 : 0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'd0:  return 32'(mChan | (mPend << 4) | (mSingle << 5));
      5'd4:  return 32'(mRes);
      5'd8:  return 32'(mEoc);
      5'd12: return 32'(mSamp);
      5'd16: return 32'(mPd);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    case (a)
      5'd0:  return "R2";
      5'd4, 5'd8, 5'd12: return "R9";
      5'd16: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mPd = 1; mChan = 0; mSingle = 0; mPend = 0; mSettle = 0;
      mBusy = 0; mBcnt = 0; mCv = 0; mRes = 0; mEoc = 0; mSamp = 0;
    end else begin
      int launch, done, wCfg, wPwr;
      launch = modelLaunch();
      done   = (mBusy != 0 && mPd == 0 && mBcnt == CONV - 1) ? 1 : 0;
      wCfg   = (busWe && busAddr == 5'd0) ? 1 : 0;
      wPwr   = (busWe && busAddr == 5'd16) ? 1 : 0;
      if (mPd != 0) mBusy = 0;
      else if (launch != 0) begin mBusy = 1; mBcnt = 0; mCv = mChan; end
      else if (done != 0) mBusy = 0;
      else if (mBusy != 0) mBcnt++;
      if (launch != 0) mEoc = 0;
      else if (done != 0) begin mEoc = 1; mRes = 100 + 100 * mCv; mSamp = mCv; end
      if (wPwr != 0 && busWdata[0]) begin
        mPd = 1; mPend = 0; mSettle = 0;
      end else begin
        if (wPwr != 0 && mPd != 0) begin mPd = 0; mSettle = 0; end
        else if (mPd == 0 && mSettle < SETTLE) mSettle++;
        if (wCfg != 0 && busWdata[4]) mPend = 1;
        else if (launch != 0) mPend = 0;
      end
      if (wCfg != 0) begin mChan = int'(busWdata[2:0]); mSingle = int'(busWdata[5]); end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R4", 32'(coreStart), 32'(modelLaunch()));
      check("R6", 32'(corePowerDown), 32'(mPd));
      check("R8", 32'(coreChanSel), 32'(mChan));
      check("R8", 32'(coreSingleMode), 32'(mSingle));
      check(tagFor(busAddr), busRdata, modelRead(busAddr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    readCheck("R1", 5'd16, 32'd1);
    readCheck("R1", 5'd0, 32'd0);
    readCheck("R1", 5'd8, 32'd0);
    readCheck("R1", 5'd4, 32'd0);
    readCheck("R1", 5'd12, 32'd0);

    // R2 R3 R5: start while powered down stays pending
    writeReg(5'd0, 32'h33);
    readCheck("R3", 5'd0, 32'h33);
    idle(20);
    readCheck("R5", 5'd0, 32'h33);
    check("R5", 32'(coreStart), 32'd0);

    // R4: launch right after the 8th edge following power-up
    writeReg(5'd16, 32'd0);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2;
      n++;
      if (coreStart) break;
    end
    check("R4", 32'(n), 32'(SETTLE));
    check("R8", 32'(coreChanSel), 32'd3);
    check("R8", 32'(coreSingleMode), 32'd1);

    // R9 result capture, R3 self-clear
    idle(8);
    readCheck("R9", 5'd4, 32'd400);
    readCheck("R9", 5'd12, 32'd3);
    readCheck("R9", 5'd8, 32'd1);
    readCheck("R3", 5'd0, 32'h23);

    // R7: redundant power-up does not restart settling
    writeReg(5'd16, 32'd0);
    writeReg(5'd0, 32'h15);
    check("R7", 32'(coreStart), 32'd1);
    idle(1);
    readCheck("R8", 5'd8, 32'd0);

    // R11: start while busy held until the conversion finishes
    writeReg(5'd0, 32'h16);
    readCheck("R11", 5'd0, 32'h16);
    idle(20);
    readCheck("R11", 5'd4, 32'd700);
    readCheck("R11", 5'd12, 32'd6);

    // R12: power-down aborts a running conversion
    writeReg(5'd0, 32'h11);
    idle(1);
    writeReg(5'd16, 32'd1);
    idle(10);
    readCheck("R12", 5'd8, 32'd0);
    readCheck("R12", 5'd4, 32'd700);
    readCheck("R6", 5'd16, 32'd1);

    // R6: power-down discards a pending start
    writeReg(5'd0, 32'h17);
    readCheck("R6", 5'd0, 32'h17);
    writeReg(5'd16, 32'd1);
    readCheck("R6", 5'd0, 32'h07);
    writeReg(5'd16, 32'd0);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2;
      if (coreStart) n++;
    end
    check("R6", 32'(n), 32'd0);

    // R8: channel 7, single mode off
    writeReg(5'd0, 32'h17);
    check("R8", 32'(coreStart), 32'd1);
    check("R8", 32'(coreChanSel), 32'd7);
    check("R8", 32'(coreSingleMode), 32'd0);
    idle(10);
    readCheck("R10", 5'd4, 32'd800);

    // R10: unmapped and misaligned reads
    readCheck("R10", 5'd20, 32'd0);
    readCheck("R10", 5'd24, 32'd0);
    readCheck("R10", 5'd28, 32'd0);
    readCheck("R10", 5'd2, 32'd0);

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule